// File: doc/BRIEF.md
# Synchronous Serial Transfer Start Controller

This block is the master side of a clocked serial port. It has a single 8-bit shift register and no transmit or receive buffer, so every transfer moves one byte out and one byte in at the same time. A host reaches the port through a register-style interface: a data write strobe, a data read strobe, and two enable levels, one for transmit and one for receive. On the serial side the block drives a serial clock, a serial data output with its own output-enable, and it samples a serial data input.

The two enable levels decide what starts a transfer. With transmit enabled, a data write starts it. With only receive enabled, a data read starts it, and so does turning receive on while transmit is off. With both enables off, no access starts anything. When transmit is off, the output-enable is low so the line can float. When receive is off, zeros are shifted in instead of the input pin. With both enabled, the port reads back its own bits, which lets software compare the received byte with the byte it wrote and so detect a conflict on the line.

The serial clock is the system clock divided by a fixed parameter. It idles high. Data goes out most significant bit first, changes on the falling edge and is sampled on the rising edge. A busy level covers the whole transfer, and a one-cycle done pulse marks its end.

Top module: `sxp_serial_port`

## Requirements
- R1: After reset, busy and done are 0, sck is 1, rd_data is 0, and sdo_oe is 0 while tx_en is 0.
- R2: sdo_oe equals tx_en. sdo presents the shift register most significant bit first. Bit 7 appears at the start, and each later bit appears only in the cycle where sck falls.
- R3: On each rising sck, the bit shifted into bit 0 is sdi when rx_en is 1 and a constant 0 when rx_en is 0.
- R4: With tx_en=0 and rx_en=0, neither a write nor a read starts a transfer.
- R5: With tx_en=0 and rx_en=1, a read strobe starts a transfer. rd_data always shows the shift register, so that read returns the byte from the previous transfer. A write in this mode starts nothing.
- R6: With tx_en=1, for either value of rx_en, a write strobe loads wr_data and starts a transfer. A read in this mode starts nothing.
- R7: With tx_en=0, a change of rx_en from 0 to 1 starts a transfer. With tx_en=1, the same change starts nothing.
- R8: A write while idle with tx_en=0 stores wr_data without starting a transfer. Setting tx_en to 1 later starts no transfer, because nothing is kept pending.
- R9: Write or read strobes and rx_en edges that arrive while busy are ignored. The shift register is not reloaded and no extra transfer or done pulse follows.
- R10: busy is high for exactly 2*8*DIV_HALF cycles, starting the cycle after the start request. sck is low for DIV_HALF cycles, then high for DIV_HALF cycles, eight times, and is high whenever busy is 0. done is high for one cycle, in the first cycle that busy is 0 again.
- R11: With both enables at 1 and sdi tied to sdo, rd_data after the transfer equals the byte written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable level |
| rx_en | input | 1 | Receive enable level |
| wr_stb | input | 1 | One-cycle data register write strobe |
| wr_data | input | DATA_W | Write data |
| rd_stb | input | 1 | One-cycle data register read strobe |
| rd_data | output | DATA_W | Shift register contents |
| sck | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output enable for sdo (0 = high impedance) |
| sdi | input | 1 | Serial data input |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle transfer completion pulse |

## Verification
The bench tries every combination of the two enables against both a write and a read, so that each start rule is separated from its neighbours. Full 256-value sweeps then run in three modes. In loopback, the output is wired back to the input, and this proves bit order and self-reception. In transmit-only mode, the slave drives the complement of each byte, which shows that the input is forced to zero. In receive-only mode, read strobes chain the transfers and a scrambled slave byte shows that the pin is sampled and that a read returns the previous byte. Separate sequences try an rx_en edge under each transmit setting, a write stored while transmit is off and never started later, and strobes sent during a busy transfer.

// File: rtl/sxp_pkg.sv
package sxp_pkg;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_WRITE  = 2'd1,
    SRC_READ   = 2'd2,
    SRC_RXEDGE = 2'd3
  } start_src_e;

  // Start-source decision from the enable levels and the current events.
  function automatic start_src_e pick_start(input logic tx, input logic rx,
                                            input logic wr, input logic rd,
                                            input logic rx_rise);
    start_src_e s;
    s = SRC_NONE;
    if (tx) begin
      if (wr) s = SRC_WRITE;
    end else if (rx && rd) begin
      s = SRC_READ;
    end else if (rx_rise) begin
      s = SRC_RXEDGE;
    end
    return s;
  endfunction

  // Length in system cycles of one transfer: a low and a high phase per bit.
  function automatic int unsigned xfer_ticks(input int unsigned bits,
                                             input int unsigned half);
    return 2 * bits * half;
  endfunction

endpackage

// File: rtl/sxp_start.sv
module sxp_start (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic rx_en,
  input  logic wr_stb,
  input  logic rd_stb,
  input  logic busy,
  output logic start
);
  import sxp_pkg::*;

  logic       rx_q;
  logic       rx_rise;
  start_src_e src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= 1'b0;
    else        rx_q <= rx_en;
  end

  assign rx_rise = rx_en && !rx_q;

  always_comb begin
    src = pick_start(tx_en, rx_en, wr_stb, rd_stb, rx_rise);
  end

  // Requests during a transfer are dropped, never queued.
  assign start = (src != SRC_NONE) && !busy;

endmodule

// File: rtl/sxp_sclk.sv
module sxp_sclk #(
  parameter int BITS     = 8,
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic sck,
  output logic rise_evt,
  output logic fall_evt,
  output logic done
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int BW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [CW-1:0] HALF_LAST = CW'(DIV_HALF - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(BITS - 1);

  logic [CW-1:0] half_cnt;
  logic [BW-1:0] bit_cnt;
  logic          half_end;
  logic          last_evt;

  assign half_end = (half_cnt == HALF_LAST);
  assign rise_evt = busy && !sck && half_end;
  assign fall_evt = busy && sck && half_end && (bit_cnt != BIT_LAST);
  assign last_evt = busy && sck && half_end && (bit_cnt == BIT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      sck      <= 1'b1;
      done     <= 1'b0;
      half_cnt <= '0;
      bit_cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          sck      <= 1'b0;
          half_cnt <= '0;
          bit_cnt  <= '0;
        end
      end else if (half_end) begin
        half_cnt <= '0;
        if (rise_evt) begin
          sck <= 1'b1;
        end else if (last_evt) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          sck     <= 1'b0;
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else begin
        half_cnt <= half_cnt + 1'b1;
      end
    end
  end

  // Run-length tracker used only by the length check below.
  logic [31:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_len <= '0;
    else if (!busy) run_len <= '0;
    else            run_len <= run_len + 1'b1;
  end

  AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck); // R10
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R10
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_len == 32'(sxp_pkg::xfer_ticks(BITS, DIV_HALF)))); // R10

endmodule

// File: rtl/sxp_shift.sv
module sxp_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] wdata,
  input  logic              start,
  input  logic              busy,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              rx_en,
  input  logic              sdi,
  output logic [DATA_W-1:0] shreg,
  output logic              sdo_q
);
  logic in_bit;

  // With receive off, the incoming bit is forced low.
  assign in_bit = rx_en ? sdi : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      sdo_q <= 1'b0;
    end else begin
      if (take) begin
        shreg <= wdata;
        sdo_q <= wdata[DATA_W-1];
      end else if (start) begin
        sdo_q <= shreg[DATA_W-1];
      end else if (rise_evt) begin
        shreg <= {shreg[DATA_W-2:0], in_bit};
      end else if (fall_evt) begin
        sdo_q <= shreg[DATA_W-1];
      end
    end
  end

  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(fall_evt)) |-> $stable(sdo_q)); // R2
  AST_RX_FORCED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rise_evt && !rx_en) |-> !shreg[0]); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && !$past(take)) |-> $stable(shreg)); // R8

endmodule

// File: rtl/sxp_serial_port.sv
module sxp_serial_port #(
  parameter int DATA_W   = 8,
  parameter int DIV_HALF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  output logic              sck,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              sdi,
  output logic              busy,
  output logic              done
);
  logic start;
  logic take;
  logic rise_evt;
  logic fall_evt;
  logic sdo_q;
  logic [DATA_W-1:0] shreg;

  // Any idle write stores the byte; it only starts a transfer with tx_en set.
  assign take = wr_stb && !busy;

  sxp_start u_start (
    .clk    (clk),
    .rst_n  (rst_n),
    .tx_en  (tx_en),
    .rx_en  (rx_en),
    .wr_stb (wr_stb),
    .rd_stb (rd_stb),
    .busy   (busy),
    .start  (start)
  );

  sxp_sclk #(.BITS(DATA_W), .DIV_HALF(DIV_HALF)) u_sclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .sck      (sck),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .done     (done)
  );

  sxp_shift #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .wdata    (wr_data),
    .start    (start),
    .busy     (busy),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .rx_en    (rx_en),
    .sdi      (sdi),
    .shreg    (shreg),
    .sdo_q    (sdo_q)
  );

  assign rd_data = shreg;
  assign sdo     = sdo_q;
  assign sdo_oe  = tx_en;

  AST_START_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(wr_stb && tx_en) || $past(!tx_en && rx_en))); // R4

endmodule

// File: tb/sim_sxp_serial_port.sv
module sim_sxp_serial_port;
  localparam int BITS = 8;
  localparam int HALF = 2;
  localparam int XT   = 2 * BITS * HALF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 1'b0, rx_en = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic sck, sdo, sdo_oe, sdi, busy, done;

  int n_chk = 0, n_fail = 0, cyc = 0, done_cnt = 0, rise_cnt = 0, sdo_bad = 0;
  logic [7:0] tx_cap = 8'h00, slave = 8'h00;
  logic loop = 1'b0;
  logic prev_sdo = 1'b0, prev_sck = 1'b1, prev_busy = 1'b0;

  sxp_serial_port #(.DATA_W(BITS), .DIV_HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
    .sck(sck), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi),
    .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  function automatic logic slave_bit(input logic [7:0] b, input int k);
    if (k < 8 && k >= 0) return b[7-k];
    return 1'b0;
  endfunction

  always_comb sdi = loop ? sdo : slave_bit(slave, rise_cnt);

  always @(posedge sck) begin
    rise_cnt <= rise_cnt + 1;
    tx_cap   <= {tx_cap[6:0], sdo};
  end

  always @(posedge clk) if (rst_n && done) done_cnt <= done_cnt + 1;

  // Output may move only together with a falling sck while a transfer runs.
  always @(negedge clk) begin
    if (rst_n && busy && prev_busy && (sdo != prev_sdo) && !(prev_sck && !sck))
      sdo_bad <= sdo_bad + 1;
    prev_sdo  <= sdo;
    prev_sck  <= sck;
    prev_busy <= busy;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected < 150000)", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    tick(1);
  endtask

  task automatic set_en(input logic t, input logic r);
    tx_en = 1'b0; rx_en = 1'b0;
    tick(2);
    rise_cnt = 0;
    tx_en = t; rx_en = r;
    tick(2);
    wait_idle();
  endtask

  task automatic wr(input logic [7:0] v);
    rise_cnt = 0;
    wr_data = v; wr_stb = 1'b1;
    tick(1);
    wr_stb = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    rise_cnt = 0;
    rd_stb = 1'b1;
    #1 v = rd_data;
    tick(1);
    rd_stb = 1'b0;
  endtask

  task automatic measure(output int len);
    len = 0;
    while (busy) begin
      len++;
      tick(1);
    end
  endtask

  initial begin
    logic [7:0] v, prev_exp;
    int len, d0;
    bit exp_start;
    string tag;

    tick(3);
    chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    chk(sck == 1'b1, "R1", "sck in reset", int'(sck), 1);
    rst_n = 1'b1;
    tick(2);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    chk(rd_data == 8'h00, "R1", "rd_data after reset", int'(rd_data), 0);
    chk(sdo_oe == 1'b0, "R1", "sdo_oe after reset", int'(sdo_oe), 0);

    // Start-rule sweep: every enable pair against write and read.
    loop = 1'b1;
    for (int t = 0; t < 2; t++) begin
      for (int r = 0; r < 2; r++) begin
        for (int k = 0; k < 2; k++) begin
          set_en(t[0], r[0]);
          chk(sdo_oe == t[0], "R2", "sdo_oe follows tx_en", int'(sdo_oe), t);
          if (k == 0) wr(8'h5A); else rd(v);
          exp_start = (t == 1) ? (k == 0) : (r == 1 && k == 1);
          tag = (t == 1) ? "R6" : ((r == 1) ? "R5" : "R4");
          chk(busy == exp_start, tag, "start from access", int'(busy), int'(exp_start));
          if (busy) begin
            measure(len);
            chk(len == XT, "R10", "busy length", len, XT);
            chk(done == 1'b1, "R10", "done with busy fall", int'(done), 1);
            tick(1);
            chk(done == 1'b0, "R10", "done one cycle", int'(done), 0);
            chk(sck == 1'b1, "R10", "sck idle high", int'(sck), 1);
          end
          tick(2);
        end
      end
    end

    // Receive-enable edge.
    set_en(1'b0, 1'b0);
    rx_en = 1'b1;
    tick(1);
    chk(busy == 1'b1, "R7", "rx_en rise starts with tx off", int'(busy), 1);
    wait_idle();
    set_en(1'b1, 1'b0);
    rx_en = 1'b1;
    tick(1);
    chk(busy == 1'b0, "R7", "rx_en rise ignored with tx on", int'(busy), 0);
    tick(2);

    // Write with transmit off: stored, never started later.
    set_en(1'b0, 1'b0);
    wr(8'hA5);
    chk(busy == 1'b0, "R8", "write with tx off", int'(busy), 0);
    tx_en = 1'b1;
    tick(20);
    chk(busy == 1'b0, "R8", "no pending start", int'(busy), 0);
    tx_en = 1'b0;
    tick(1);
    rd(v);
    chk(v == 8'hA5, "R8", "stored byte", int'(v), 'hA5);

    // Loopback sweep.
    set_en(1'b1, 1'b1);
    loop = 1'b1;
    for (int i = 0; i < 256; i++) begin
      wr(i[7:0]);
      wait_idle();
      rd(v);
      chk(v == i[7:0], "R11", "loopback byte", int'(v), i);
      chk(tx_cap == i[7:0], "R2", "msb-first output", int'(tx_cap), i);
    end

    // Transmit only: input forced to zero.
    set_en(1'b1, 1'b0);
    loop = 1'b0;
    for (int i = 0; i < 256; i++) begin
      slave = ~i[7:0];
      wr(i[7:0]);
      wait_idle();
      rd(v);
      chk(v == 8'h00, "R3", "rx off shifts zeros", int'(v), 0);
      chk(tx_cap == i[7:0], "R2", "tx-only output", int'(tx_cap), i);
    end

    // Receive only: reads chain transfers.
    slave = 8'h00;
    set_en(1'b0, 1'b1);
    prev_exp = 8'h00;
    for (int i = 0; i < 256; i++) begin
      slave = i[7:0] ^ 8'h3C;
      rd(v);
      if (i > 0) chk(v == prev_exp, "R3", "sampled sdi byte", int'(v), int'(prev_exp));
      chk(busy == 1'b1, "R5", "read starts rx transfer", int'(busy), 1);
      prev_exp = slave;
      wait_idle();
    end
    set_en(1'b0, 1'b0);
    rd(v);
    chk(v == prev_exp, "R5", "last received byte", int'(v), int'(prev_exp));

    // Requests while busy.
    set_en(1'b1, 1'b1);
    loop = 1'b1;
    d0 = done_cnt;
    wr(8'h3C);
    tick(4);
    wr(8'hFF);
    tick(2);
    rd_stb = 1'b1; tick(1); rd_stb = 1'b0;
    wait_idle();
    tick(3);
    chk(done_cnt - d0 == 1, "R9", "single done pulse", done_cnt - d0, 1);
    chk(busy == 1'b0, "R9", "no extra transfer", int'(busy), 0);
    rd(v);
    chk(v == 8'h3C, "R9", "busy write ignored", int'(v), 'h3C);

    chk(sdo_bad == 0, "R2", "sdo moves only on sck fall", sdo_bad, 0);

    summary();
    $finish;
  end

endmodule